// File: doc/BRIEF.md
# Dual FIFO with Independently Rewindable Pointers

This block holds two first-in first-out stores. Each store keeps 4096 words of 12 bits and has its own write enable, read enable, output enable and flags. The write side and the read side each have their own pointer reset. Rewinding only the read pointer lets stored data be read a second time. Rewinding only the write pointer lets old locations be written again.

Both stores share one clock. Each store derives full, empty, almost-full and almost-empty from the difference of its two pointers. The pointers are one bit wider than the address, so this difference is taken modulo twice the depth and is recomputed after any rewind. The two almost-thresholds are offsets that are loaded over a shared threshold bus through an active-low load strobe for each channel.

Top module: `fifo_rp_dual`

## Requirements
- R1: After `rst_n` is low at a rising edge, every channel shows empty=1, full=0, almost_empty=1 and almost_full=0, and `rd_data` is zero. Both pointers are at location 0, and the offsets return to their parameter defaults of 8 each.
- R2: An accepted write stores `wr_data` at the write pointer. An accepted read returns the word at the read pointer on `rd_data` one clock later. A read and a write may both be accepted in the same cycle. Full and empty are never high together.
- R3: A high `rd_rst` returns only the read pointer to location 0. Stored data and the write pointer are unchanged, so the words from location 0 onward can be read again.
- R4: A high `wr_rst` returns only the write pointer to location 0. Occupancy is then (write pointer − read pointer) mod 8192, so a rewind past unread data can leave the channel reporting full.
- R5: Full is high when occupancy is 4096 or more. A write while full is ignored and leaves both data and flags unchanged.
- R6: Empty is high when occupancy is 0. A read while empty is ignored, and `rd_data` keeps its last value.
- R7: almost_empty is high exactly when occupancy ≤ the empty offset.
- R8: almost_full is high exactly when occupancy ≥ 4096 − the full offset.
- R9: When `thr_ld_n[c]` is low at a rising edge, `thr_val` is loaded into channel c. After reset the first load goes to the empty offset, the next load goes to the full offset, and later loads keep alternating. The new offset governs the flags from the next cycle.
- R10: A low `oe[c]` forces `rd_data` of channel c to zero. It does not change which words are read or stored.
- R11: A pointer reset takes priority over an enable on the same side in the same cycle. The pointer goes to 0 and no write or read takes place.
- R12: The channels are independent. Any stimulus on one channel leaves the outputs of the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both channels |
| rst_n | input | 1 | Active-low synchronous reset of everything |
| thr_val | input | 12 | Offset value for threshold loads |
| thr_ld_n | input | 2 | Active-low threshold load strobe, one per channel |
| wr_en | input | 2 | Write enable per channel |
| rd_en | input | 2 | Read enable per channel |
| wr_rst | input | 2 | Write-pointer rewind per channel |
| rd_rst | input | 2 | Read-pointer rewind per channel |
| oe | input | 2 | Read-data output enable per channel |
| wr_data | input | 24 | Write words, channel c at bits [12c+11:12c] |
| rd_data | output | 24 | Read words, channel c at bits [12c+11:12c] |
| full | output | 2 | Full flag per channel |
| empty | output | 2 | Empty flag per channel |
| almost_full | output | 2 | Almost-full flag per channel |
| almost_empty | output | 2 | Almost-empty flag per channel |

## Verification
All four flags come from the registered pointers and offsets, so each flag reflects a write, read, rewind or threshold load one rising edge after that edge. Read data also appears one edge after the read is accepted. The output-enable gating acts within the same cycle. The bench changes inputs only on falling edges. It steps a behavioural model on each rising edge and compares every output of both channels on the falling edge that follows, which is exactly where each result is due.

// File: rtl/fifo_rp_pkg.sv
package fifo_rp_pkg;
    // which offset the next threshold load writes
    typedef enum logic {
        SEL_EMPTY_OFF = 1'b0,
        SEL_FULL_OFF  = 1'b1
    } thr_sel_e;
endpackage

// File: rtl/fifo_rp_ptr.sv
module fifo_rp_ptr #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          wr_rst,
    input  logic          rd_rst,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   occ,
    output logic          full,
    output logic          empty
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
    } ptr_t;

    ptr_t st_d, st_q;

    always_comb begin
        occ     = st_q.wp - st_q.rp;
        full    = (occ >= PW'(DEPTH));
        empty   = (occ == '0);
        wr_ok   = wr_en && !wr_rst && !full;
        rd_ok   = rd_en && !rd_rst && !empty;
        wr_addr = st_q.wp[AW-1:0];
        rd_addr = st_q.rp[AW-1:0];
        st_d    = st_q;
        if (wr_rst)     st_d.wp = '0;
        else if (wr_ok) st_d.wp = st_q.wp + PW'(1);
        if (rd_rst)     st_d.rp = '0;
        else if (rd_ok) st_d.rp = st_q.rp + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fifo_rp_thr.sv
module fifo_rp_thr
    import fifo_rp_pkg::*;
#(
    parameter int AW     = 12,
    parameter int AE_DEF = 8,
    parameter int AF_DEF = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_n,
    input  logic [AW-1:0] thr_val,
    input  logic [AW:0]   occ,
    output logic          almost_full,
    output logic          almost_empty
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [AW-1:0] ae_off;
        logic [AW-1:0] af_off;
        thr_sel_e      sel;
    } thr_t;

    thr_t st_d, st_q;

    always_comb begin
        almost_empty = (occ <= {1'b0, st_q.ae_off});
        almost_full  = (occ >= (PW'(DEPTH) - {1'b0, st_q.af_off}));
        st_d = st_q;
        if (!ld_n) begin
            if (st_q.sel == SEL_EMPTY_OFF) begin
                st_d.ae_off = thr_val;
                st_d.sel    = SEL_FULL_OFF;
            end else begin
                st_d.af_off = thr_val;
                st_d.sel    = SEL_EMPTY_OFF;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ae_off <= AW'(AE_DEF);
            st_q.af_off <= AW'(AF_DEF);
            st_q.sel    <= SEL_EMPTY_OFF;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fifo_rp_ram.sv
module fifo_rp_ram #(
    parameter int AW = 12,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ok,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_ok,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] dout
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] dout_d, dout_q;

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_addr] <= wr_data;
    end

    always_comb begin
        dout_d = dout_q;
        if (rd_ok) dout_d = mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dout_q <= '0;
        else        dout_q <= dout_d;
    end

    assign dout = dout_q;
endmodule

// File: rtl/fifo_rp_chan.sv
module fifo_rp_chan #(
    parameter int AW     = 12,
    parameter int DW     = 12,
    parameter int AE_DEF = 8,
    parameter int AF_DEF = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] thr_val,
    input  logic          thr_ld_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          wr_rst,
    input  logic          rd_rst,
    input  logic          oe,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          full,
    output logic          empty,
    output logic          almost_full,
    output logic          almost_empty
);
    logic          wr_ok, rd_ok;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [AW:0]   occ;
    logic [DW-1:0] dout;

    fifo_rp_ptr #(.AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .rd_en(rd_en), .wr_rst(wr_rst), .rd_rst(rd_rst),
        .wr_ok(wr_ok), .rd_ok(rd_ok), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .occ(occ), .full(full), .empty(empty)
    );

    fifo_rp_thr #(.AW(AW), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_thr (
        .clk(clk), .rst_n(rst_n), .ld_n(thr_ld_n), .thr_val(thr_val),
        .occ(occ), .almost_full(almost_full), .almost_empty(almost_empty)
    );

    fifo_rp_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .wr_ok(wr_ok), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_ok(rd_ok), .rd_addr(rd_addr), .dout(dout)
    );

    assign rd_data = oe ? dout : '0;
endmodule

// File: rtl/fifo_rp_dual.sv
module fifo_rp_dual #(
    parameter int NCH    = 2,
    parameter int AW     = 12,
    parameter int DW     = 12,
    parameter int AE_DEF = 8,
    parameter int AF_DEF = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     thr_val,
    input  logic [NCH-1:0]    thr_ld_n,
    input  logic [NCH-1:0]    wr_en,
    input  logic [NCH-1:0]    rd_en,
    input  logic [NCH-1:0]    wr_rst,
    input  logic [NCH-1:0]    rd_rst,
    input  logic [NCH-1:0]    oe,
    input  logic [NCH*DW-1:0] wr_data,
    output logic [NCH*DW-1:0] rd_data,
    output logic [NCH-1:0]    full,
    output logic [NCH-1:0]    empty,
    output logic [NCH-1:0]    almost_full,
    output logic [NCH-1:0]    almost_empty
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        fifo_rp_chan #(.AW(AW), .DW(DW), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_ch (
            .clk(clk), .rst_n(rst_n), .thr_val(thr_val), .thr_ld_n(thr_ld_n[c]),
            .wr_en(wr_en[c]), .rd_en(rd_en[c]), .wr_rst(wr_rst[c]), .rd_rst(rd_rst[c]),
            .oe(oe[c]), .wr_data(wr_data[c*DW +: DW]), .rd_data(rd_data[c*DW +: DW]),
            .full(full[c]), .empty(empty[c]),
            .almost_full(almost_full[c]), .almost_empty(almost_empty[c])
        );
    end
endmodule

// File: rtl/fifo_rp_dual_chk.sv
module fifo_rp_dual_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] wr_en,
    input logic [NCH-1:0] rd_en,
    input logic [NCH-1:0] wr_rst,
    input logic [NCH-1:0] rd_rst,
    input logic [NCH-1:0] full,
    input logic [NCH-1:0] empty,
    input logic [NCH-1:0] almost_full,
    input logic [NCH-1:0] almost_empty
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R2
        full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(full[c] && empty[c]));
        // R5
        full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (full[c] && !rd_en[c] && !rd_rst[c] && !wr_rst[c]) |=> full[c]);
        // R6
        empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (empty[c] && !wr_en[c] && !wr_rst[c] && !rd_rst[c]) |=> empty[c]);
        // R7
        empty_implies_ae_chk: assert property (@(posedge clk) disable iff (!rst_n)
            empty[c] |-> almost_empty[c]);
        // R8
        full_implies_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
            full[c] |-> almost_full[c]);
    end
endmodule

bind fifo_rp_dual fifo_rp_dual_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .wr_rst(wr_rst), .rd_rst(rd_rst), .full(full), .empty(empty),
    .almost_full(almost_full), .almost_empty(almost_empty)
);

// File: tb/fifo_rp_dual_test.sv
module fifo_rp_dual_test;
    localparam int NCH = 2, AW = 12, DW = 12, DEPTH = 4096, PMOD = 8192;

    logic clk = 1'b0;
    logic rst_n;
    logic [AW-1:0] thr_val;
    logic [NCH-1:0] thr_ld_n, wr_en, rd_en, wr_rst, rd_rst, oe;
    logic [NCH*DW-1:0] wr_data, rd_data;
    logic [NCH-1:0] full, empty, almost_full, almost_empty;

    int n_tests = 0, n_fail = 0;
    string req = "R1";
    bit done = 0;

    // behavioural model state
    int mwp [NCH], mrp [NCH], mdout [NCH], mae [NCH], maf [NCH], msel [NCH];
    int mmem [NCH][DEPTH];

    always #4 clk = ~clk;

    fifo_rp_dual #(.NCH(NCH), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .thr_val(thr_val), .thr_ld_n(thr_ld_n),
        .wr_en(wr_en), .rd_en(rd_en), .wr_rst(wr_rst), .rd_rst(rd_rst), .oe(oe),
        .wr_data(wr_data), .rd_data(rd_data), .full(full), .empty(empty),
        .almost_full(almost_full), .almost_empty(almost_empty)
    );

    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                mwp[c] = 0; mrp[c] = 0; mdout[c] = 0;
                mae[c] = 8; maf[c] = 8; msel[c] = 0;
            end else begin
                int occ;
                bit wok, rok;
                occ = (mwp[c] - mrp[c] + PMOD) % PMOD;
                wok = wr_en[c] && !wr_rst[c] && occ < DEPTH;
                rok = rd_en[c] && !rd_rst[c] && occ != 0;
                if (rok) mdout[c] = mmem[c][mrp[c] % DEPTH];
                if (wok) mmem[c][mwp[c] % DEPTH] = int'(wr_data[c*DW +: DW]);
                if (wr_rst[c]) mwp[c] = 0; else if (wok) mwp[c] = (mwp[c] + 1) % PMOD;
                if (rd_rst[c]) mrp[c] = 0; else if (rok) mrp[c] = (mrp[c] + 1) % PMOD;
                if (!thr_ld_n[c]) begin
                    if (msel[c] == 0) mae[c] = int'(thr_val); else maf[c] = int'(thr_val);
                    msel[c] = 1 - msel[c];
                end
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        for (int c = 0; c < NCH; c++) begin
            int occ;
            occ = (mwp[c] - mrp[c] + PMOD) % PMOD;
            chk($sformatf("ch%0d full", c), int'(full[c]), int'(occ >= DEPTH));
            chk($sformatf("ch%0d empty", c), int'(empty[c]), int'(occ == 0));
            chk($sformatf("ch%0d almost_empty", c), int'(almost_empty[c]), int'(occ <= mae[c]));
            chk($sformatf("ch%0d almost_full", c), int'(almost_full[c]), int'(occ >= DEPTH - maf[c]));
            chk($sformatf("ch%0d rd_data", c), int'(rd_data[c*DW +: DW]), oe[c] ? mdout[c] : 0);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        wr_en = '0; rd_en = '0; wr_rst = '0; rd_rst = '0; thr_ld_n = '1;
    endtask

    task automatic put(input int c, input int v);
        idle(); wr_en[c] = 1'b1; wr_data[c*DW +: DW] = DW'(v); tick();
    endtask

    task automatic get(input int c);
        idle(); rd_en[c] = 1'b1; tick();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; idle(); oe = '1; thr_val = '0; wr_data = '0;
        req = "R1";
        tick(); tick();
        rst_n = 1'b1; tick();

        // R2: ordered data with one-cycle read latency on channel 0
        req = "R2";
        for (int i = 0; i < 10; i++) put(0, (i * 37 + 5) & 12'hFFF);
        for (int i = 0; i < 4; i++) get(0);
        idle(); wr_en[0] = 1'b1; rd_en[0] = 1'b1; wr_data[11:0] = 12'h5A5; tick();
        for (int i = 0; i < 7; i++) get(0);

        // R6: reads while empty are ignored, data held
        req = "R6";
        for (int i = 0; i < 3; i++) get(0);

        // R9: load empty offset then full offset
        req = "R9";
        idle(); thr_ld_n[0] = 1'b0; thr_val = 12'd3; tick();
        idle(); thr_ld_n[0] = 1'b0; thr_val = 12'd5; tick();
        idle(); tick();

        // R7: sweep occupancy across the empty offset
        req = "R7";
        for (int i = 0; i < 6; i++) put(0, 100 + i);
        for (int i = 0; i < 6; i++) get(0);

        // R8 / R5: fill to full, then extra writes are ignored
        req = "R8";
        for (int i = 0; i < DEPTH; i++) put(0, (i * 11 + 1) & 12'hFFF);
        req = "R5";
        for (int i = 0; i < 3; i++) put(0, 12'hABC);
        req = "R8";
        for (int i = 0; i < 7; i++) get(0);

        // R3: rewind read pointer, re-read from location 0
        req = "R3";
        idle(); rd_rst[0] = 1'b1; tick();
        for (int i = 0; i < 4; i++) get(0);

        // R11: rewinds win over enables on the same side
        req = "R11";
        idle(); rd_rst[0] = 1'b1; rd_en[0] = 1'b1; tick();
        idle(); wr_rst[0] = 1'b1; wr_en[0] = 1'b1; wr_data[11:0] = 12'h777; tick();
        idle(); rd_rst[0] = 1'b1; tick();
        for (int i = 0; i < 2; i++) get(0);

        // R4: rewinding the write pointer past unread data
        req = "R4";
        idle(); rd_rst[0] = 1'b1; wr_rst[0] = 1'b1; tick();
        for (int i = 0; i < 20; i++) put(0, 300 + i);
        for (int i = 0; i < 5; i++) get(0);
        idle(); wr_rst[0] = 1'b1; tick();
        put(0, 12'h111);
        get(0);
        idle(); rd_rst[0] = 1'b1; tick();

        // R10: output enable low hides data, state continues
        req = "R10";
        for (int i = 0; i < 3; i++) put(0, 12'h800 + i);
        oe[0] = 1'b0;
        get(0); get(0);
        oe[0] = 1'b1;
        idle(); tick();
        get(0);

        // R12: channel 1 traffic alongside channel 0 activity
        req = "R12";
        for (int i = 0; i < 12; i++) begin
            idle();
            wr_en[1] = 1'b1; wr_data[23:12] = DW'(i * 5 + 2);
            rd_en[0] = (i % 3 == 0); wr_en[0] = (i % 2 == 0);
            wr_data[11:0] = DW'(i + 40);
            tick();
        end
        idle(); thr_ld_n[1] = 1'b0; thr_val = 12'd11; tick();
        for (int i = 0; i < 14; i++) begin
            idle(); rd_en[1] = 1'b1; tick();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule